// File: doc/BRIEF.md
# Sampling-Converter Serial Output Sequencer

This block models the digital side of a 16-bit sampling converter's serial port. The host supplies an active-low chip select and a serial clock. The block runs on its own system clock, which must be much faster than the serial clock. It brings both host signals into that clock domain through a parameterised synchroniser and detects their edges there.

When chip select falls, the block:

- latches the sample word from a parallel input,
- enables its data driver with the first leading zero already on the line,
- raises a hold status.

Each later falling edge of the serial clock moves the frame on by one bit. The frame is four leading zeros, then the sample MSB first, then four trailing zeros. After the frame ends, the driver stays released.

The driver is released at once in two cases:

- chip select rises, which aborts the frame;
- the frame reaches its final falling edge.

The hold status drops on the first serial-clock rising edge after seventeen falling edges have been counted. It also drops when chip select rises.

The data line is modelled as a drive enable plus a data bit. An outer wrapper can turn this pair into a true three-state pin.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is active and straight after it, `sdo_oe`, `sdo` and `hold` are all 0.
- R2: After a chip-select falling edge, and before any serial-clock edge, `sdo_oe` is 1, `sdo` is 0 (the first leading zero) and `hold` is 1.
- R3: The sample word is captured on the chip-select fall. Later changes of `sample_in` within the frame do not affect `sdo`.
- R4: After the n-th serial-clock falling edge of a frame, `sdo` is 0 for n = 1..3. For n = 4..19, `sdo` is `sample[19-n]`, so the word goes out MSB first. `sdo_oe` stays 1 throughout.
- R5: After falling edges 20 to 23, `sdo_oe` is 1 and `sdo` is 0 (trailing zeros).
- R6: From falling edge 24 on, including any extra edges, `sdo_oe` is 0.
- R7: A chip-select rise at any point of a frame clears `sdo_oe` and `hold`.
- R8: `hold` stays 1 through the first 17 falling edges and the rising edges between them. It clears on the first rising edge after the 17th falling edge.
- R9: Serial-clock activity while chip select is high has no effect: `sdo_oe`, `sdo` and `hold` stay 0.
- R10: When a chip-select rise and a serial-clock falling edge reach the block in the same cycle, the abort wins. The output is released and the bit does not advance.
- R11: Whenever `sdo_oe` is 0, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sample_in | input | DATA_W | Parallel sample word, captured on the chip-select fall |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Data driver enable (0 means high impedance) |
| hold | output | 1 | Track/hold status, 1 while holding |

## Verification
A chip-select rise and a serial-clock falling edge can reach the block in the same system-clock cycle. In that cycle, releasing the frame and advancing the bit compete for the output register.

The bench provokes this on purpose. It drives chip select high and the serial clock low on the same system-clock edge. Both pass through synchronisers of equal depth, so they arrive together. This is done at a random falling-edge count inside the frame.

The bench then expects `sdo_oe`, `sdo` and `hold` all at 0. A design that advanced the bit would instead show the driver enabled with the next frame bit.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

   typedef struct packed {
      logic cs_fall;
      logic cs_rise;
      logic sck_fall;
      logic sck_rise;
   } adcsp_evt_t;

endpackage

// File: rtl/adcsp_edge_det.sv
module adcsp_edge_det
   import adcsp_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sclk,
   output adcsp_evt_t evt
);

   logic cs_s;
   logic sk_s;
   logic cs_p;
   logic sk_p;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign cs_s = cs_n;
         assign sk_s = sclk;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] cs_c;
         logic [SYNC_STAGES-1:0] sk_c;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_c <= '1;
               sk_c <= '1;
            end else begin
               for (int i = SYNC_STAGES - 1; i > 0; i--) begin
                  cs_c[i] <= cs_c[i-1];
                  sk_c[i] <= sk_c[i-1];
               end
               cs_c[0] <= cs_n;
               sk_c[0] <= sclk;
            end
         end
         assign cs_s = cs_c[SYNC_STAGES-1];
         assign sk_s = sk_c[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_p <= 1'b1;
         sk_p <= 1'b1;
      end else begin
         cs_p <= cs_s;
         sk_p <= sk_s;
      end
   end

   always_comb begin
      evt.cs_fall  = cs_p & ~cs_s;
      evt.cs_rise  = ~cs_p & cs_s;
      evt.sck_fall = sk_p & ~sk_s;
      evt.sck_rise = ~sk_p & sk_s;
   end

endmodule

// File: rtl/adcsp_frame_ctl.sv
module adcsp_frame_ctl
   import adcsp_pkg::*;
#(
   parameter int FRAME_LEN  = 24,
   parameter int HOLD_FALLS = 17,
   parameter int CNT_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  adcsp_evt_t       evt,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             in_frame,
   output logic             bit_adv,
   output logic             hold
);

   localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_LEN);
   localparam logic [CNT_W-1:0] CNT_HOLD = CNT_W'(HOLD_FALLS);

   // Saturate at the frame end so extra edges keep the line released.
   assign cnt_nxt = (cnt == CNT_END) ? cnt : cnt + 1'b1;
   assign bit_adv = in_frame & evt.sck_fall & ~evt.cs_rise & ~evt.cs_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         in_frame <= 1'b0;
         hold     <= 1'b0;
      end else if (evt.cs_fall) begin
         cnt      <= '0;
         in_frame <= 1'b1;
         hold     <= 1'b1;
      end else if (evt.cs_rise) begin
         in_frame <= 1'b0;
         hold     <= 1'b0;
      end else if (in_frame) begin
         if (bit_adv)
            cnt <= cnt_nxt;
         if (evt.sck_rise && cnt >= CNT_HOLD)
            hold <= 1'b0;
      end
   end

endmodule

// File: rtl/adcsp_shifter.sv
module adcsp_shifter
   import adcsp_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int LEAD_Z    = 4,
   parameter int FRAME_LEN = 24,
   parameter int CNT_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  adcsp_evt_t        evt,
   input  logic              bit_adv,
   input  logic [CNT_W-1:0]  cnt_nxt,
   input  logic [DATA_W-1:0] sample_in,
   output logic              sdo,
   output logic              sdo_oe
);

   localparam int POS_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   logic [DATA_W-1:0] word_q;
   logic              bit_nxt;
   logic              last_nxt;
   logic [POS_W-1:0]  pos;

   always_comb begin
      int k;
      k        = int'(cnt_nxt);
      last_nxt = (k >= FRAME_LEN);
      pos      = '0;
      bit_nxt  = 1'b0;
      if (k >= LEAD_Z && k < LEAD_Z + DATA_W) begin
         pos     = POS_W'(DATA_W - 1 - (k - LEAD_Z));
         bit_nxt = word_q[pos];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         sdo    <= 1'b0;
         sdo_oe <= 1'b0;
      end else if (evt.cs_fall) begin
         word_q <= sample_in;
         sdo    <= 1'b0;
         sdo_oe <= 1'b1;
      end else if (evt.cs_rise) begin
         sdo    <= 1'b0;
         sdo_oe <= 1'b0;
      end else if (bit_adv) begin
         sdo    <= last_nxt ? 1'b0 : bit_nxt;
         sdo_oe <= ~last_nxt;
      end
   end

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
   import adcsp_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int LEAD_Z      = 4,
   parameter int TRAIL_Z     = 4,
   parameter int HOLD_FALLS  = 17,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic [DATA_W-1:0] sample_in,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              hold
);

   localparam int FRAME_LEN = LEAD_Z + DATA_W + TRAIL_Z;
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);

   generate
      if (DATA_W < 1)
         $error("adc_serial_port: DATA_W must be at least 1");
      if (LEAD_Z < 1)
         $error("adc_serial_port: LEAD_Z must be at least 1");
      if (TRAIL_Z < 0)
         $error("adc_serial_port: TRAIL_Z must not be negative");
      if (HOLD_FALLS < 1 || HOLD_FALLS > FRAME_LEN)
         $error("adc_serial_port: HOLD_FALLS out of frame range");
      if (SYNC_STAGES < 0)
         $error("adc_serial_port: SYNC_STAGES must not be negative");
   endgenerate

   adcsp_evt_t       evt;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;
   logic             in_frame;
   logic             bit_adv;

   adcsp_edge_det #(
      .SYNC_STAGES(SYNC_STAGES)
   ) edge_i (
      .clk  (clk),
      .rst_n(rst_n),
      .cs_n (cs_n),
      .sclk (sclk),
      .evt  (evt)
   );

   adcsp_frame_ctl #(
      .FRAME_LEN (FRAME_LEN),
      .HOLD_FALLS(HOLD_FALLS),
      .CNT_W     (CNT_W)
   ) ctl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .cnt     (cnt),
      .cnt_nxt (cnt_nxt),
      .in_frame(in_frame),
      .bit_adv (bit_adv),
      .hold    (hold)
   );

   adcsp_shifter #(
      .DATA_W   (DATA_W),
      .LEAD_Z   (LEAD_Z),
      .FRAME_LEN(FRAME_LEN),
      .CNT_W    (CNT_W)
   ) shf_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .bit_adv  (bit_adv),
      .cnt_nxt  (cnt_nxt),
      .sample_in(sample_in),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe)
   );

endmodule

// File: rtl/adcsp_chk.sv
module adcsp_chk #(
   parameter int FRAME_LEN  = 24,
   parameter int HOLD_FALLS = 17,
   parameter int CNT_W      = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sdo,
   input logic             sdo_oe,
   input logic             hold,
   input logic             cs_rise,
   input logic             in_frame,
   input logic [CNT_W-1:0] cnt
);

   p_quiet_low_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe |-> !sdo);

   p_start_zero_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> (hold && !sdo));

   p_abort_release_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> (!sdo_oe && !hold));

   p_frame_end_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(FRAME_LEN)) |-> !sdo_oe);

   p_hold_release_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold) |-> (cnt >= CNT_W'(HOLD_FALLS) || !in_frame));

   p_idle_quiet_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !in_frame |-> !sdo_oe);

endmodule

bind adc_serial_port adcsp_chk #(
   .FRAME_LEN (FRAME_LEN),
   .HOLD_FALLS(HOLD_FALLS),
   .CNT_W     (CNT_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .sdo     (sdo),
   .sdo_oe  (sdo_oe),
   .hold    (hold),
   .cs_rise (evt.cs_rise),
   .in_frame(in_frame),
   .cnt     (cnt)
);

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b1;
   logic [15:0] sample_in = '0;
   logic        sdo;
   logic        sdo_oe;
   logic        hold;

   int  vectors = 0;
   int  miscompares = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_serial_port dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .sample_in(sample_in),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe),
      .hold     (hold)
   );

   function automatic logic exp_bit(logic [15:0] w, int n);
      if (n >= 4 && n < 20) return w[19-n];
      return 1'b0;
   endfunction

   function automatic string tag_for(int n);
      if (n < 20) return "R4";
      if (n < 24) return "R5";
      return "R6";
   endfunction

   task automatic chk(string req, string what, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic wait_h();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic check_idle(string req);
      chk(req, "sdo_oe", sdo_oe, 1'b0);
      chk(req, "sdo", sdo, 1'b0);
      chk(req, "hold", hold, 1'b0);
   endtask

   task automatic run_frame(logic [15:0] w, int nfall, bit coincide);
      sample_in = w;
      cs_n = 1'b0;
      wait_h();
      chk("R2", "sdo_oe", sdo_oe, 1'b1);
      chk("R2", "sdo", sdo, 1'b0);
      chk("R2", "hold", hold, 1'b1);
      sample_in = ~w;  // R3: must not reach the line
      for (int n = 1; n <= nfall; n++) begin
         if (coincide && n == nfall) begin
            cs_n = 1'b1;
            sclk = 1'b0;
            wait_h();
            check_idle("R10");
            chk("R11", "sdo", sdo, 1'b0);
            sclk = 1'b1;
            wait_h();
            return;
         end
         sclk = 1'b0;
         wait_h();
         chk(tag_for(n), "sdo_oe", sdo_oe, (n < 24));
         chk((n >= 4 && n < 20) ? "R3" : tag_for(n), "sdo", sdo, exp_bit(w, n));
         chk("R8", "hold after fall", hold, (n <= 17));
         sclk = 1'b1;
         wait_h();
         chk("R8", "hold after rise", hold, (n < 17));
      end
      cs_n = 1'b1;
      wait_h();
      check_idle("R7");
   endtask

   initial begin
      void'($urandom(32'h5EED_0A1D));
      repeat (3) @(negedge clk);
      check_idle("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");

      // R9: serial clock toggling with chip select high
      for (int i = 0; i < 4; i++) begin
         sclk = 1'b0; wait_h();
         check_idle("R9");
         sclk = 1'b1; wait_h();
         check_idle("R9");
      end

      // directed corners
      run_frame(16'h8001, 24, 1'b0);
      run_frame(16'hFFFF, 20, 1'b0);
      run_frame(16'hA5C3, 27, 1'b0);   // extra falls past the end (R6)
      run_frame(16'h1234, 3, 1'b0);    // abort in leading zeros (R7)
      run_frame(16'h7FFE, 17, 1'b0);   // abort right at hold boundary
      run_frame(16'hFFFF, 10, 1'b1);   // coincident abort mid data (R10)
      run_frame(16'h0000, 1, 1'b1);

      // random frames
      for (int i = 0; i < 40; i++) begin
         logic [15:0] w;
         int nf;
         w  = 16'($urandom);
         nf = 1 + int'($urandom % 26);
         run_frame(w, nf, ($urandom % 3) == 0);
         for (int j = 0; j < 2; j++) begin
            sclk = 1'b0; wait_h();
            sclk = 1'b1; wait_h();
         end
         check_idle("R9");
      end

      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule